// File: doc/BRIEF.md
# Management-Frame PHY Register Model

This block models a small Ethernet PHY register file as seen through a 32-bit management-frame register. A single write to the frame register starts one access to one PHY register. A read copies the selected register into the low half of the frame register, and a write updates the selected register. Every access completes in the cycle it is written. A completion pulse follows each access.

The model holds a control word, a status word, an advertisement word, an 8-bit interrupt mask and an interrupt-source word. It also answers with constant identity and capability values. An asynchronous link-level input is synchronised, and each edge of it updates the status and source bits exactly once. The PHY interrupt output is high when any source bit is enabled by the mask.

Top module: `mgmt_phy_model`

## Requirements
- R1: The frame register resets to 0. A frame write with bit 29 clear is a PHY write, and the frame register then holds the written word. A frame write with bit 29 set is a PHY read, and the frame register then holds the written bits 31:16 with the PHY value in bits 15:0. The register index is taken from bits 27:18 and the data from bits 15:0.
- R2: `mgmt_done` is high for exactly the one cycle after each frame write, and low otherwise.
- R3: After reset the registers read as follows: index 0 (control) 0x3000, index 1 (status) 0x7809, index 4 (advertisement) 0x01E1, index 29 (source) 0, index 30 (mask) 0. The constants read as 0x0007 at index 2, 0xC0D1 at index 3, 0x0F71 at index 5 and 0x0001 at index 6.
- R4: A control write with bit 15 clear stores the data ANDed with 0x7980. If data bit 12 is set, the write also sets status bit 5.
- R5: An advertisement write stores (data AND 0x2D7F) OR 0x0080.
- R6: A control write with bit 15 set restores control, advertisement, mask and status to their reset values. It then applies the current synchronised link level as a link event: link up gives status 0x782D and source 0x00C0, and link down gives status 0x7809 and source 0x0010.
- R7: Reading index 29 returns the source bits and then clears them. A second read returns 0.
- R8: A rising link edge sets status bits 5 and 2 and source bits 7 and 6. A falling link edge clears status bits 5 and 2 and sets source bit 4. Each edge acts exactly once.
- R9: A write to index 30 stores data bits 7:0 as the mask. `phy_irq` is high exactly when (source AND mask) is nonzero.
- R10: Indices 7 to 28, index 31 and all indices above 31 read as 0. Writes to these indices and to the constant indices change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_wr | input | 1 | Write strobe for the frame register |
| frame_wdata | input | 32 | Frame word being written |
| frame_q | output | 32 | Current frame register contents |
| mgmt_done | output | 1 | Access-complete pulse |
| link_in | input | 1 | Asynchronous link level |
| phy_irq | output | 1 | Masked OR of the interrupt-source bits |

## Verification
The hardest situations to reach from the ports are a soft reset with the link held up and the clear-on-read of the source word. Both depend on link-edge state that only shows after the synchroniser delay. The stimulus moves `link_in` and waits several cycles before each check. It arms the mask so that `phy_irq` reveals the source bits without reading them. It then reads index 29 twice, so the value is seen once and the clear is seen on the second read. A soft reset is issued once with the link down and once with it up, and the status and source words are compared against both outcomes.

// File: rtl/mgmt_phy_pkg.sv
// Shared constants and types for the management-frame PHY model.
// Assumes a 32-bit frame with the op bit, index field and data field at fixed positions.
package mgmt_phy_pkg;
    localparam int FRAME_W  = 32;
    localparam int DATA_W   = 16;
    localparam int IDX_W    = 10;
    localparam int IDX_LSB  = 18;
    localparam int OP_BIT   = 29;
    localparam int MASK_W   = 8;

    localparam logic [IDX_W-1:0] IX_CTRL = IDX_W'(0);
    localparam logic [IDX_W-1:0] IX_STAT = IDX_W'(1);
    localparam logic [IDX_W-1:0] IX_ID_A = IDX_W'(2);
    localparam logic [IDX_W-1:0] IX_ID_B = IDX_W'(3);
    localparam logic [IDX_W-1:0] IX_ADV  = IDX_W'(4);
    localparam logic [IDX_W-1:0] IX_LPA  = IDX_W'(5);
    localparam logic [IDX_W-1:0] IX_EXP  = IDX_W'(6);
    localparam logic [IDX_W-1:0] IX_SRC  = IDX_W'(29);
    localparam logic [IDX_W-1:0] IX_MSK  = IDX_W'(30);

    localparam logic [DATA_W-1:0] CTRL_INIT  = 16'h3000;
    localparam logic [DATA_W-1:0] STAT_INIT  = 16'h7809;
    localparam logic [DATA_W-1:0] ADV_INIT   = 16'h01E1;
    localparam logic [DATA_W-1:0] CTRL_KEEP  = 16'h7980;
    localparam logic [DATA_W-1:0] ADV_KEEP   = 16'h2D7F;
    localparam logic [DATA_W-1:0] ADV_FORCE  = 16'h0080;
    localparam logic [DATA_W-1:0] LINK_STAT  = 16'h0024;
    localparam logic [DATA_W-1:0] ANEG_DONE  = 16'h0020;
    localparam logic [DATA_W-1:0] ID_A_VAL   = 16'h0007;
    localparam logic [DATA_W-1:0] ID_B_VAL   = 16'hC0D1;
    localparam logic [DATA_W-1:0] LPA_VAL    = 16'h0F71;
    localparam logic [DATA_W-1:0] EXP_VAL    = 16'h0001;
    localparam logic [MASK_W-1:0] SRC_UP     = 8'hC0;
    localparam logic [MASK_W-1:0] SRC_DOWN   = 8'h10;

    localparam int CTRL_RST_BIT  = 15;
    localparam int CTRL_ANEG_BIT = 12;

    typedef struct packed {
        logic              valid;
        logic              is_read;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } phy_access_t;
endpackage

// File: rtl/mgmt_link_sync.sv
// Synchronises the asynchronous link level and emits one-cycle rise/fall events.
// Assumes STAGES >= 2; the level and events come out of registered state.
module mgmt_link_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic link_in,
    output logic link_lvl,
    output logic evt_up,
    output logic evt_dn
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            // One flop of the synchroniser chain.
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= link_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    // Remember the last synchronised level so that edges are seen once.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign link_lvl = chain_q[STAGES-1];
    assign evt_up   = chain_q[STAGES-1] & ~prev_q;
    assign evt_dn   = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/mgmt_frame_reg.sv
// Frame register: decodes a written frame into one PHY access and stores the result word.
// Assumes the PHY read data is valid combinationally in the cycle of the write.
module mgmt_frame_reg
    import mgmt_phy_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_wr,
    input  logic [FRAME_W-1:0] frame_wdata,
    input  logic [DATA_W-1:0]  phy_rdata,
    output phy_access_t        acc,
    output logic [FRAME_W-1:0] frame_q,
    output logic               done_q
);
    // Split the incoming frame into op, index and data fields.
    always_comb begin
        acc.valid   = frame_wr;
        acc.is_read = frame_wdata[OP_BIT];
        acc.idx     = frame_wdata[IDX_LSB +: IDX_W];
        acc.data    = frame_wdata[DATA_W-1:0];
    end

    // Capture the written word, merging read data into the low half on a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
        end else if (frame_wr) begin
            if (frame_wdata[OP_BIT]) frame_q <= {frame_wdata[FRAME_W-1:DATA_W], phy_rdata};
            else                     frame_q <= frame_wdata;
        end
    end

    // Completion pulse for every access.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= frame_wr;
    end
endmodule

// File: rtl/mgmt_phy_regs.sv
// PHY register file: control, status, advertisement, interrupt mask and source.
// Assumes at most one access per cycle; link events and accesses in one cycle merge.
module mgmt_phy_regs
    import mgmt_phy_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  phy_access_t       acc,
    input  logic              link_lvl,
    input  logic              evt_up,
    input  logic              evt_dn,
    output logic [DATA_W-1:0] rdata,
    output logic [MASK_W-1:0] src_q,
    output logic [MASK_W-1:0] mask_q
);
    logic [DATA_W-1:0] ctrl_q, stat_q, adv_q;
    logic [DATA_W-1:0] ctrl_d, stat_d, adv_d;
    logic [MASK_W-1:0] src_d, mask_d;
    logic              wr_hit, soft_rst;

    // Read multiplexer over the implemented indices; everything else reads zero.
    always_comb begin
        case (acc.idx)
            IX_CTRL: rdata = ctrl_q;
            IX_STAT: rdata = stat_q;
            IX_ID_A: rdata = ID_A_VAL;
            IX_ID_B: rdata = ID_B_VAL;
            IX_ADV:  rdata = adv_q;
            IX_LPA:  rdata = LPA_VAL;
            IX_EXP:  rdata = EXP_VAL;
            IX_SRC:  rdata = DATA_W'(src_q);
            IX_MSK:  rdata = DATA_W'(mask_q);
            default: rdata = '0;
        endcase
    end

    // Next-state: soft reset, register writes, clear-on-read and link events.
    always_comb begin
        wr_hit   = acc.valid & ~acc.is_read;
        soft_rst = wr_hit & (acc.idx == IX_CTRL) & acc.data[CTRL_RST_BIT];
        ctrl_d = ctrl_q;
        stat_d = stat_q;
        adv_d  = adv_q;
        mask_d = mask_q;
        src_d  = src_q;
        if (soft_rst) begin
            ctrl_d = CTRL_INIT;
            adv_d  = ADV_INIT;
            mask_d = '0;
            if (link_lvl) begin
                stat_d = STAT_INIT | LINK_STAT;
                src_d  = SRC_UP;
            end else begin
                stat_d = STAT_INIT & ~LINK_STAT;
                src_d  = SRC_DOWN;
            end
        end else begin
            if (wr_hit && acc.idx == IX_CTRL) begin
                ctrl_d = acc.data & CTRL_KEEP;
                if (acc.data[CTRL_ANEG_BIT]) stat_d = stat_d | ANEG_DONE;
            end
            if (wr_hit && acc.idx == IX_ADV) adv_d = (acc.data & ADV_KEEP) | ADV_FORCE;
            if (wr_hit && acc.idx == IX_MSK) mask_d = acc.data[MASK_W-1:0];
            if (acc.valid && acc.is_read && acc.idx == IX_SRC) src_d = '0;
            if (evt_up) begin
                stat_d = stat_d | LINK_STAT;
                src_d  = src_d | SRC_UP;
            end
            if (evt_dn) begin
                stat_d = stat_d & ~LINK_STAT;
                src_d  = src_d | SRC_DOWN;
            end
        end
    end

    // State registers with hardware reset values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_INIT;
            stat_q <= STAT_INIT;
            adv_q  <= ADV_INIT;
            mask_q <= '0;
            src_q  <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            stat_q <= stat_d;
            adv_q  <= adv_d;
            mask_q <= mask_d;
            src_q  <= src_d;
        end
    end
endmodule

// File: rtl/mgmt_phy_model.sv
// Top: management frame register in front of an emulated PHY register file.
// Assumes link_in may be asynchronous; all other inputs are synchronous to clk.
module mgmt_phy_model
    import mgmt_phy_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_wr,
    input  logic [FRAME_W-1:0] frame_wdata,
    output logic [FRAME_W-1:0] frame_q,
    output logic               mgmt_done,
    input  logic               link_in,
    output logic               phy_irq
);
    phy_access_t       acc;
    logic [DATA_W-1:0] phy_rdata;
    logic [MASK_W-1:0] src_bits, mask_bits;
    logic              link_lvl, evt_up, evt_dn;

    mgmt_link_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .link_in(link_in),
        .link_lvl(link_lvl), .evt_up(evt_up), .evt_dn(evt_dn)
    );

    mgmt_frame_reg u_frame (
        .clk(clk), .rst_n(rst_n), .frame_wr(frame_wr), .frame_wdata(frame_wdata),
        .phy_rdata(phy_rdata), .acc(acc), .frame_q(frame_q), .done_q(mgmt_done)
    );

    mgmt_phy_regs u_regs (
        .clk(clk), .rst_n(rst_n), .acc(acc), .link_lvl(link_lvl),
        .evt_up(evt_up), .evt_dn(evt_dn), .rdata(phy_rdata),
        .src_q(src_bits), .mask_q(mask_bits)
    );

    assign phy_irq = |(src_bits & mask_bits);
endmodule

// File: rtl/mgmt_phy_chk.sv
// Checker for the management-frame PHY model, bound to the top module.
// Assumes synchronous active-low reset; all properties are disabled in reset.
module mgmt_phy_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        frame_wr,
    input logic [31:0] frame_wdata,
    input logic [31:0] frame_q,
    input logic        mgmt_done,
    input logic        phy_irq,
    input logic [7:0]  mask_bits,
    input logic [7:0]  src_bits,
    input logic        evt_up,
    input logic        evt_dn
);
    p_done_after_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_wr |=> mgmt_done);
    p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_wr |=> !mgmt_done);
    p_frame_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_wr |=> $stable(frame_q));
    p_wr_copy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_wr && !frame_wdata[29]) |=> frame_q == $past(frame_wdata));
    p_rd_upper_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_wr && frame_wdata[29]) |=> frame_q[31:16] == $past(frame_wdata[31:16]));
    p_irq_needs_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        phy_irq |-> (mask_bits != 8'h00 && src_bits != 8'h00));
    p_edge_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_up || evt_dn) |=> !(evt_up || evt_dn));
    p_edge_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt_up && evt_dn));
endmodule

bind mgmt_phy_model mgmt_phy_chk u_chk (
    .clk(clk), .rst_n(rst_n), .frame_wr(frame_wr), .frame_wdata(frame_wdata),
    .frame_q(frame_q), .mgmt_done(mgmt_done), .phy_irq(phy_irq),
    .mask_bits(mask_bits), .src_bits(src_bits), .evt_up(evt_up), .evt_dn(evt_dn)
);

// File: tb/test_mgmt_phy_model.sv
module test_mgmt_phy_model;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_wr = 1'b0;
    logic [31:0] frame_wdata = '0;
    logic [31:0] frame_q;
    logic        mgmt_done;
    logic        link_in = 1'b0;
    logic        phy_irq;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mgmt_phy_model i_mgmt_phy_model (
        .clk(clk), .rst_n(rst_n), .frame_wr(frame_wr), .frame_wdata(frame_wdata),
        .frame_q(frame_q), .mgmt_done(mgmt_done), .link_in(link_in), .phy_irq(phy_irq)
    );

    // {requirement number, frame word written, expected frame word afterwards}
    localparam logic [71:0] VEC [NVEC] = '{
        {8'd3,  32'h2000_0000, 32'h2000_3000},  // R3 control
        {8'd3,  32'h2004_0000, 32'h2004_7809},  // R3 status
        {8'd1,  32'h2008_ABCD, 32'h2008_0007},  // R1 low half replaced, R3 id
        {8'd3,  32'h200C_0000, 32'h200C_C0D1},  // R3
        {8'd3,  32'h2010_0000, 32'h2010_01E1},  // R3 advertisement
        {8'd3,  32'h2014_0000, 32'h2014_0F71},  // R3
        {8'd3,  32'h2018_0000, 32'h2018_0001},  // R3
        {8'd3,  32'h2074_0000, 32'h2074_0000},  // R3 source
        {8'd3,  32'h2078_0000, 32'h2078_0000},  // R3 mask
        {8'd10, 32'h2044_BEEF, 32'h2044_0000},  // R10 index 17
        {8'd10, 32'h20A0_1111, 32'h20A0_0000},  // R10 index 40
        {8'd1,  32'h0010_FFFF, 32'h0010_FFFF},  // R1 write copy
        {8'd5,  32'h2010_0000, 32'h2010_2DFF},  // R5
        {8'd1,  32'h0000_1234, 32'h0000_1234},  // R1
        {8'd4,  32'h2000_0000, 32'h2000_1000},  // R4 masked control
        {8'd4,  32'h2004_0000, 32'h2004_7829},  // R4 autoneg status bit
        {8'd10, 32'h0008_FFFF, 32'h0008_FFFF},  // R10 write to constant
        {8'd10, 32'h2008_0000, 32'h2008_0007},  // R10 unchanged
        {8'd9,  32'h0078_FF10, 32'h0078_FF10},  // R9 mask write
        {8'd9,  32'h2078_0000, 32'h2078_0010}   // R9 mask is 8 bits
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic access(input logic [31:0] w);
        @(negedge clk);
        frame_wr = 1'b1;
        frame_wdata = w;
        @(negedge clk);
        frame_wr = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        wait_cycles(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 R2 R9 reset state
        check("R1", frame_q, 32'h0);
        check("R2", {31'h0, mgmt_done}, 32'h0);
        check("R9", {31'h0, phy_irq}, 32'h0);

        for (int v = 0; v < NVEC; v++) begin
            access(VEC[v][63:32]);
            check($sformatf("R%0d", VEC[v][71:64]), frame_q, VEC[v][31:0]);
        end

        // R2 pulse lasts one cycle
        access(32'h2004_0000);
        check("R2", {31'h0, mgmt_done}, 32'h1);
        @(negedge clk);
        check("R2", {31'h0, mgmt_done}, 32'h0);

        // R8 link up
        link_in = 1'b1;
        wait_cycles(6);
        access(32'h2004_0000);
        check("R8", frame_q, 32'h2004_782D);
        check("R9", {31'h0, phy_irq}, 32'h0);
        access(32'h0078_00C0);
        check("R9", {31'h0, phy_irq}, 32'h1);
        // R7 clear on read
        access(32'h2074_0000);
        check("R7", frame_q, 32'h2074_00C0);
        check("R7", {31'h0, phy_irq}, 32'h0);
        wait_cycles(4);
        access(32'h2074_0000);
        check("R7", frame_q, 32'h2074_0000);

        // R8 link down
        link_in = 1'b0;
        wait_cycles(6);
        access(32'h2004_0000);
        check("R8", frame_q, 32'h2004_7809);
        check("R9", {31'h0, phy_irq}, 32'h0);
        access(32'h0078_0010);
        check("R9", {31'h0, phy_irq}, 32'h1);

        // R6 soft reset with link down
        access(32'h0000_8000);
        check("R6", {31'h0, phy_irq}, 32'h0);
        access(32'h2000_0000);
        check("R6", frame_q, 32'h2000_3000);
        access(32'h2004_0000);
        check("R6", frame_q, 32'h2004_7809);
        access(32'h2010_0000);
        check("R6", frame_q, 32'h2010_01E1);
        access(32'h2078_0000);
        check("R6", frame_q, 32'h2078_0000);
        access(32'h2074_0000);
        check("R6", frame_q, 32'h2074_0010);

        // R6 soft reset with link up
        link_in = 1'b1;
        wait_cycles(6);
        access(32'h0000_8000);
        access(32'h2004_0000);
        check("R6", frame_q, 32'h2004_782D);
        access(32'h2074_0000);
        check("R6", frame_q, 32'h2074_00C0);

        finish_run();
    end
endmodule